// File: doc/BRIEF.md
# Byte-Wide Nonvolatile Data Memory Controller with Write Unlock

This block sits on a microcontroller's internal register bus and manages a small byte-wide nonvolatile data store. Software reaches it through four byte registers: a data register, an address register, a control register and an unlock register that can only be written. A read command copies the addressed byte into the data register at the next clock edge. A write takes a fixed number of clock cycles and starts only after a guarded sequence.

The guard works as follows. Software writes 55h and then AAh to the unlock register. It then sets the write bit, and only while write-enable is already set. Once the write is under way it runs to the end on the address and data captured at its start. At the end, hardware drops the write bit and raises a completion flag, and the flag drives the interrupt output. Two resets exist. A power-on reset clears every register. A warm reset clears the control bits, keeps data and address, abandons a write that is in progress and records that event in an error bit.

Top module: `nvm_byte_ctl`

## Requirements
- R1: Registers sit at bus offsets data 08h, address 09h, control 88h and unlock 89h. The address register keeps only its low 6 bits, and its upper bits read as 0.
- R2: Control bits are: bit 0 read command, bit 1 write busy, bit 2 write enable, bit 3 error, bit 4 done flag. Bits 7..5 read 0, bit 0 always reads 0, and the unlock register always reads 0. Software may write the error bit freely.
- R3: Writing the control register with bit 0 set loads the byte at the current address into the data register, where it can be read right after that clock edge. The data register then holds until the next read command or the next software write to it.
- R4: A write starts only when the unlock register receives 55h, then AAh, and the next bus write is to control with bit 1 set. Any other bus write cancels the sequence. A 55h write always restarts the sequence at its first step.
- R5: Bit 1 cannot be set unless write enable was already 1 before that control write.
- R6: After a write starts, bit 1 reads 1 for exactly WRITE_CYCLES cycles. At completion the byte captured from the data register at the start is stored at the address captured at the start.
- R7: At completion, bit 1 clears and bit 4 sets, and irq follows bit 4. Writing 0 to bit 4 clears it. Writing 1 to bit 4 has no effect.
- R8: Clearing write enable while a write is in progress neither aborts nor changes that write.
- R9: Hardware never clears write enable, except through reset. It stays 1 after a write completes.
- R10: A read command issued while a write is in progress is ignored, and the data register keeps its value.
- R11: Power-on reset clears the control register, including the error bit. Warm reset clears bits 4, 2, 1 and 0, keeps the data and address registers, sets the error bit if a write was in progress (otherwise leaves it unchanged), and abandons that write with the memory unchanged.
- R12: The unlock sequence covers one byte only. Setting bit 1 again without a fresh sequence starts no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| rst_n | input | 1 | Warm reset, synchronous, active low |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register offset for reads and writes |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational on bus_addr |
| irq | output | 1 | Write-done interrupt, equal to the done flag |

## Verification
On every cycle, assertions check the following:
- A write starts only from the armed unlock state with write enable already set.
- The done flag rises only when a write ends.
- Every end of a write outside reset leaves the flag set.
- Write enable falls only on a control write or a reset.
- Any bus write disarms the unlock sequence.

Only the bench scenarios can show the rest:
- which byte lands at which address, including a near-exhaustive sweep of all 64 locations;
- the exact length of the busy window;
- that broken unlock sequences and reads during a write leave memory and the data register untouched;
- the register contents kept or changed by a warm reset in the middle of a write.

// File: rtl/nvm_byte_pkg.sv
package nvm_byte_pkg;
   // Control register bit positions: software decodes these
   localparam int CB_RD   = 0;
   localparam int CB_WR   = 1;
   localparam int CB_WREN = 2;
   localparam int CB_ERR  = 3;
   localparam int CB_FLAG = 4;

   typedef enum logic [1:0] {
      UL_IDLE  = 2'd0,
      UL_GOT_A = 2'd1,
      UL_ARMED = 2'd2
   } ul_state_t;
endpackage

// File: rtl/nvm_unlock_seq.sv
module nvm_unlock_seq
   import nvm_byte_pkg::*;
#(
   parameter int                BUS_AW   = 8,
   parameter int                DW       = 8,
   parameter logic [BUS_AW-1:0] UNLK_OFS = '0,
   parameter logic [DW-1:0]     KEY_A    = '0,
   parameter logic [DW-1:0]     KEY_B    = '1
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic              armed
);
   ul_state_t state_q, state_d;
   logic      hit_unlk;

   if (KEY_A == KEY_B) begin : g_bad_keys
      $error("unlock keys must differ");
   end

   assign hit_unlk = bus_we && (bus_addr == UNLK_OFS);

   always_comb begin
      state_d = state_q;
      if (bus_we) begin
         if (hit_unlk && bus_wdata == KEY_A)
            state_d = UL_GOT_A;
         else if (hit_unlk && bus_wdata == KEY_B && state_q == UL_GOT_A)
            state_d = UL_ARMED;
         else
            state_d = UL_IDLE;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)      state_q <= UL_IDLE;
      else if (!rst_n) state_q <= UL_IDLE;
      else             state_q <= state_d;
   end

   assign armed = (state_q == UL_ARMED);

   // R4: arming only directly follows the second key
   a_r4_arm_after_key_b : assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      $rose(armed) |-> $past(hit_unlk && bus_wdata == KEY_B));

   // R4: any bus write consumes the armed state
   a_r4_write_disarms : assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      ($past(armed) && $past(bus_we)) |-> !armed);
endmodule

// File: rtl/nvm_write_timer.sv
module nvm_write_timer #(
   parameter int CYCLES = 8
) (
   input  logic clk,
   input  logic por_n,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   if (CYCLES < 1) begin : g_bad_cycles
      $error("CYCLES must be at least 1");
   end

   if (CYCLES == 1) begin : g_single
      logic busy_q;
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)      busy_q <= 1'b0;
         else if (!rst_n) busy_q <= 1'b0;
         else if (start)  busy_q <= 1'b1;
         else             busy_q <= 1'b0;
      end
      assign busy = busy_q;
      assign done = busy_q;
   end else begin : g_count
      localparam int CW = $clog2(CYCLES);
      logic [CW-1:0] cnt_q;
      logic          busy_q;
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= CW'(CYCLES - 1);
         end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
         end
      end
      assign busy = busy_q;
      assign done = busy_q && (cnt_q == '0);

      // R6: the remaining count never exceeds the programmed duration
      a_r6_count_in_range : assert property (@(posedge clk) disable iff (!por_n || !rst_n)
         busy_q |-> (int'(cnt_q) < CYCLES));
   end

   // R12: a new write is never launched on top of a running one
   a_r12_start_when_idle : assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      start |-> !busy);
endmodule

// File: rtl/nvm_cell_array.sv
module nvm_cell_array #(
   parameter int AW = 6,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   if (AW < 1 || AW > 10) begin : g_bad_aw
      $error("AW out of range");
   end

   logic [DW-1:0] cells [DEPTH];

   // Nonvolatile contents: no reset
   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/nvm_byte_ctl.sv
module nvm_byte_ctl
   import nvm_byte_pkg::*;
#(
   parameter int                BUS_AW       = 8,
   parameter int                DW           = 8,
   parameter int                AW           = 6,
   parameter int                WRITE_CYCLES = 8,
   parameter logic [BUS_AW-1:0] OFS_DATA     = BUS_AW'(8'h08),
   parameter logic [BUS_AW-1:0] OFS_ADDR     = BUS_AW'(8'h09),
   parameter logic [BUS_AW-1:0] OFS_CTRL     = BUS_AW'(8'h88),
   parameter logic [BUS_AW-1:0] OFS_UNLK     = BUS_AW'(8'h89),
   parameter logic [DW-1:0]     UNLK_KEY_A   = DW'(8'h55),
   parameter logic [DW-1:0]     UNLK_KEY_B   = DW'(8'hAA)
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   output logic              irq
);
   if (DW < 5)  begin : g_bad_dw  $error("DW too narrow for control bits"); end
   if (AW > DW) begin : g_bad_aw  $error("address must fit one register"); end
   if (OFS_DATA == OFS_ADDR || OFS_DATA == OFS_CTRL || OFS_DATA == OFS_UNLK ||
       OFS_ADDR == OFS_CTRL || OFS_ADDR == OFS_UNLK || OFS_CTRL == OFS_UNLK)
   begin : g_bad_map
      $error("register offsets must be distinct");
   end

   logic          wr_data, wr_addr, wr_ctrl;
   logic          armed, busy, done, start, read_fire, cell_we;
   logic [DW-1:0] data_q, lat_data, cell_rdata;
   logic [AW-1:0] addr_q, lat_addr;
   logic          wren_q, flag_q, err_q;

   assign wr_data = bus_we && (bus_addr == OFS_DATA);
   assign wr_addr = bus_we && (bus_addr == OFS_ADDR);
   assign wr_ctrl = bus_we && (bus_addr == OFS_CTRL);

   assign start     = rst_n && wr_ctrl && bus_wdata[CB_WR] && wren_q && armed && !busy;
   assign read_fire = rst_n && wr_ctrl && bus_wdata[CB_RD] && !busy;
   assign cell_we   = rst_n && done;

   nvm_unlock_seq #(
      .BUS_AW(BUS_AW), .DW(DW), .UNLK_OFS(OFS_UNLK),
      .KEY_A(UNLK_KEY_A), .KEY_B(UNLK_KEY_B)
   ) u_unlock (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .armed(armed)
   );

   nvm_write_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
      .clk(clk), .por_n(por_n), .rst_n(rst_n),
      .start(start), .busy(busy), .done(done)
   );

   nvm_cell_array #(.AW(AW), .DW(DW)) u_cells (
      .clk(clk), .we(cell_we), .waddr(lat_addr), .wdata(lat_data),
      .raddr(addr_q), .rdata(cell_rdata)
   );

   // Data and address survive warm reset
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         data_q <= '0;
         addr_q <= '0;
      end else if (rst_n) begin
         if (read_fire)    data_q <= cell_rdata;
         else if (wr_data) data_q <= bus_wdata;
         if (wr_addr)      addr_q <= bus_wdata[AW-1:0];
      end
   end

   // Operands captured when a write is launched
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         lat_data <= '0;
         lat_addr <= '0;
      end else if (start) begin
         lat_data <= data_q;
         lat_addr <= addr_q;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         wren_q <= 1'b0;
         flag_q <= 1'b0;
         err_q  <= 1'b0;
      end else if (!rst_n) begin
         wren_q <= 1'b0;
         flag_q <= 1'b0;
         err_q  <= err_q | busy;
      end else begin
         if (wr_ctrl) begin
            wren_q <= bus_wdata[CB_WREN];
            err_q  <= bus_wdata[CB_ERR];
            if (!bus_wdata[CB_FLAG]) flag_q <= 1'b0;
         end
         if (done) flag_q <= 1'b1;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == OFS_DATA) begin
         bus_rdata = data_q;
      end else if (bus_addr == OFS_ADDR) begin
         bus_rdata[AW-1:0] = addr_q;
      end else if (bus_addr == OFS_CTRL) begin
         bus_rdata[CB_WR]   = busy;
         bus_rdata[CB_WREN] = wren_q;
         bus_rdata[CB_ERR]  = err_q;
         bus_rdata[CB_FLAG] = flag_q;
      end
   end

   assign irq = flag_q;

   // R5: a write only begins when enable was already set
   a_r5_start_needs_wren : assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      $rose(busy) |-> $past(wren_q));

   // R4: a write only begins from the armed unlock state
   a_r4_start_needs_unlock : assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      $rose(busy) |-> $past(armed));

   // R7: completion of a write leaves the flag raised
   a_r7_end_raises_flag : assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      $fell(busy) |-> (flag_q || $past(!rst_n)));

   // R7: the flag only rises out of a running write
   a_r7_flag_from_write : assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      $rose(flag_q) |-> $past(busy));

   // R9: enable falls only by software or reset
   a_r9_wren_sw_only : assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      $fell(wren_q) |-> $past(wr_ctrl || !rst_n));

   // R10: no read lands in the data register while writing
   a_r10_no_read_when_busy : assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      (busy && !wr_data) |=> $stable(data_q));
endmodule

// File: tb/nvm_byte_ctl_test.sv
module nvm_byte_ctl_test;
   localparam int NCYC = 5;
   localparam logic [7:0] A_DATA = 8'h08, A_ADDR = 8'h09, A_CTRL = 8'h88, A_UNLK = 8'h89;

   logic       clk = 1'b0;
   logic       por_n = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
   logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00, bus_rdata;
   logic       irq;
   int         checks = 0, errors = 0;
   bit         finished = 0;
   logic [7:0] model [64];

   always #4 clk = ~clk;

   nvm_byte_ctl #(.WRITE_CYCLES(NCYC)) uut (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wait_idle(output int n);
      logic [7:0] c;
      n = 0;
      bus_rd(A_CTRL, c);
      while (c[1] && n < 1000) begin
         n++;
         @(negedge clk);
         bus_rd(A_CTRL, c);
      end
   endtask

   task automatic launch(input logic [7:0] a, input logic [7:0] d);
      bus_wr(A_ADDR, a);
      bus_wr(A_DATA, d);
      bus_wr(A_CTRL, 8'h04);
      bus_wr(A_UNLK, 8'h55);
      bus_wr(A_UNLK, 8'hAA);
      bus_wr(A_CTRL, 8'h06);
   endtask

   task automatic mem_rd(input logic [7:0] a, output logic [7:0] d);
      bus_wr(A_ADDR, a);
      bus_wr(A_CTRL, 8'h01);
      bus_rd(A_DATA, d);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      int n;
      repeat (3) @(negedge clk);
      por_n = 1'b1; rst_n = 1'b1;
      @(negedge clk);

      // R11 / R2: power-on state
      bus_rd(A_CTRL, v); chk("R11 ctrl after power-on", v, 8'h00);
      bus_rd(A_UNLK, v); chk("R2 unlock reads zero", v, 8'h00);
      chk("R7 irq idle", {7'd0, irq}, 8'h00);

      // R1: address register masks to 6 bits
      bus_wr(A_ADDR, 8'hFF);
      bus_rd(A_ADDR, v); chk("R1 address mask", v, 8'h3F);

      // R2 / R7: reserved bits and flag write-1 ignored
      bus_wr(A_CTRL, 8'hF5);
      bus_rd(A_CTRL, v); chk("R2 ctrl readback", v, 8'h04);

      // R6 / R7 / R9: write every location
      for (int a = 0; a < 64; a++) begin
         model[a] = 8'((a * 37 + 11) & 8'hFF);
         launch(8'(a), model[a]);
         wait_idle(n);
         if (a < 4 || a == 63) begin
            chk("R6 busy window", 8'(n), 8'(NCYC));
            bus_rd(A_CTRL, v); chk("R7 done flag set, R9 wren kept", v, 8'h14);
            chk("R7 irq follows flag", {7'd0, irq}, 8'h01);
         end
      end

      // R7: writing 0 to the flag clears it
      bus_wr(A_CTRL, 8'h04);
      bus_rd(A_CTRL, v); chk("R7 flag cleared", v, 8'h04);

      // R3: read back all locations
      for (int a = 0; a < 64; a++) begin
         mem_rd(8'(a), v);
         chk("R3 read back", v, model[a]);
      end
      bus_rd(A_CTRL, v); chk("R2 read bit reads zero", v & 8'h01, 8'h00);

      // R3: data register holds after the address changes
      mem_rd(8'd10, v);
      bus_wr(A_ADDR, 8'd20);
      bus_rd(A_DATA, v); chk("R3 data holds", v, model[10]);

      // R4: stray write between keys
      bus_wr(A_ADDR, 8'd7); bus_wr(A_DATA, 8'hC3); bus_wr(A_CTRL, 8'h04);
      bus_wr(A_UNLK, 8'h55); bus_wr(A_DATA, 8'hC3); bus_wr(A_UNLK, 8'hAA);
      bus_wr(A_CTRL, 8'h06);
      bus_rd(A_CTRL, v); chk("R4 stray write blocks", v, 8'h04);
      // R4: keys reversed
      bus_wr(A_UNLK, 8'hAA); bus_wr(A_UNLK, 8'h55); bus_wr(A_CTRL, 8'h06);
      bus_rd(A_CTRL, v); chk("R4 reversed keys block", v, 8'h04);
      // R4: wrong second key
      bus_wr(A_UNLK, 8'h55); bus_wr(A_UNLK, 8'hAB); bus_wr(A_CTRL, 8'h06);
      bus_rd(A_CTRL, v); chk("R4 wrong key blocks", v, 8'h04);
      // R4: write between the second key and the start
      bus_wr(A_UNLK, 8'h55); bus_wr(A_UNLK, 8'hAA); bus_wr(A_ADDR, 8'd7);
      bus_wr(A_CTRL, 8'h06);
      bus_rd(A_CTRL, v); chk("R4 late stray write blocks", v, 8'h04);
      mem_rd(8'd7, v); chk("R4 memory untouched", v, model[7]);

      // R4: a repeated first key restarts the sequence
      bus_wr(A_ADDR, 8'd8); bus_wr(A_DATA, 8'h3C); bus_wr(A_CTRL, 8'h04);
      bus_wr(A_UNLK, 8'h55); bus_wr(A_UNLK, 8'h55); bus_wr(A_UNLK, 8'hAA);
      bus_wr(A_CTRL, 8'h06);
      wait_idle(n);
      chk("R4 restart still writes", 8'(n), 8'(NCYC));
      model[8] = 8'h3C;

      // R12: setting the write bit again without a new sequence
      bus_wr(A_CTRL, 8'h06);
      bus_rd(A_CTRL, v); chk("R12 no second write", v & 8'h02, 8'h00);

      // R5: write enable clear blocks the start
      bus_wr(A_CTRL, 8'h00);
      bus_wr(A_UNLK, 8'h55); bus_wr(A_UNLK, 8'hAA); bus_wr(A_CTRL, 8'h06);
      bus_rd(A_CTRL, v); chk("R5 wren needed", v, 8'h04);
      mem_rd(8'd8, v); chk("R5 memory untouched", v, 8'h3C);

      // R8 / R10: clear enable and issue a read during a write
      launch(8'd12, 8'h96);
      bus_wr(A_DATA, 8'h5A);
      bus_wr(A_CTRL, 8'h01);
      bus_rd(A_DATA, v); chk("R10 read ignored while busy", v, 8'h5A);
      bus_rd(A_CTRL, v); chk("R8 write still running", v & 8'h02, 8'h02);
      wait_idle(n);
      bus_rd(A_CTRL, v); chk("R8 write completed", v, 8'h10);
      model[12] = 8'h96;
      mem_rd(8'd12, v); chk("R8 captured data stored", v, 8'h96);

      // R11: warm reset in the middle of a write
      launch(8'd3, 8'hE1);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      bus_rd(A_CTRL, v); chk("R11 error bit after warm reset", v, 8'h08);
      chk("R11 irq cleared", {7'd0, irq}, 8'h00);
      bus_rd(A_DATA, v); chk("R11 data kept", v, 8'hE1);
      bus_rd(A_ADDR, v); chk("R11 address kept", v, 8'h03);
      repeat (NCYC + 2) @(negedge clk);
      mem_rd(8'd3, v); chk("R11 write abandoned", v, model[3]);
      bus_rd(A_CTRL, v); chk("R2 error bit written by software", v, 8'h00);

      // R11: warm reset while idle leaves the error bit alone
      bus_wr(A_CTRL, 8'h08);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      bus_rd(A_CTRL, v); chk("R11 idle reset keeps error", v, 8'h08);

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule